// File: doc/BRIEF.md
# Receive Checksum Verification Engine

This block sits in the receive stream of an Ethernet path and checks IPv4 frames on the fly. It takes one byte per beat through a valid/ready/last stream interface. It counts the byte position, picks the Ethernet type, the IPv4 header fields and the L4 protocol out of the passing bytes, and keeps three ones'-complement accumulators: one for the IPv4 header, one for the L4 segment, and one for the two addresses that go into the pseudo-header. The frame bytes pass through unchanged and with no added latency.

When the last frame byte has gone out, the block holds off its input and sends a 4-byte status trailer. The trailer beat now carries the end-of-frame flag in place of the original last byte. Each 16-bit half of the trailer reads 0x0000 when its check passes. It reads 0xFFFF when the check is switched off or does not apply. Any other value is the complement of the folded sum and marks a failed check. A 4-bit enable input chooses which checks run. Its value is taken on the first byte of each frame.

A state machine controls the output side. PASS forwards the frame; the accepted last input byte moves it to TR0. TR0, TR1, TR2 and TR3 each present one trailer byte and advance on `m_ready`. TR3 returns to PASS and clears the parser and the accumulators for the next frame.

Top module: `rx_csum_verify`

## Requirements
- R1: The output stream is every input byte of the frame, unchanged and in order, followed by exactly 4 trailer bytes; `s_ready` is low while the trailer is being sent.
- R2: `m_last` is high only on the fourth trailer byte; the input's last flag is not forwarded on the final frame byte.
- R3: Trailer byte order: byte 0 = IP half bits 15:8, byte 1 = IP half bits 7:0, byte 2 = L4 half bits 15:8, byte 3 = L4 half bits 7:0.
- R4: For a supported IPv4 frame with `chk_en[0]` set, the IP half is the complement of the folded 16-bit ones'-complement sum of the IHL*4 header bytes (bytes from offset 14, even offsets as high byte). A correct header gives 0x0000; any header, IHL 5 to 15, is covered.
- R5: For protocol 6 (`chk_en[1]`) or 17 (`chk_en[2]`), the L4 half is the complement of the folded sum of the pseudo-header (source and destination address, protocol, L4 length = total length - IHL*4) plus the segment, with an odd last byte padded with zero. For protocol 1 (`chk_en[3]`) no pseudo-header is added.
- R6: A half whose enable bit is clear is 0xFFFF, whatever the frame contents.
- R7: A frame whose Ethernet type (bytes 12-13) is not 0x0800, for example IPv6 0x86DD or ARP 0x0806, gets 0xFFFF in both halves.
- R8: Both halves are 0xFFFF when the IP version nibble is not 4, IHL < 5, total length < IHL*4, the frame has fewer than 34 bytes, or the frame has fewer than 14 + total length bytes.
- R9: A fragment (more-fragments flag, byte 20 bit 5, set or a nonzero offset) or a protocol other than 1/6/17 gives an L4 half of 0xFFFF. The IP half is still checked.
- R10: Bytes after offset 14 + total length (Ethernet padding) are forwarded but left out of both sums.
- R11: `chk_en` is sampled when the first byte of a frame is accepted; a change during a frame only affects later frames.
- R12: During frame bytes, `s_ready` follows `m_ready` and `m_valid` follows `s_valid`; a trailer byte stays stable while `m_ready` is low.
- R13: After reset the block is in PASS: `m_valid` low with no input, `m_last` low, `s_ready` equal to `m_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 4 | Check enables: bit 0 IPv4 header, bit 1 TCP, bit 2 UDP, bit 3 ICMP |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted when high with s_valid |
| s_data | input | 8 | Input frame byte |
| s_last | input | 1 | Last byte of the input frame |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 8 | Output byte (frame byte or trailer byte) |
| m_last | output | 1 | Last trailer byte |

## Verification
The bench sweeps segment lengths of both parities for TCP, UDP and ICMP, with correct and corrupted sums, across all sixteen enable codes. It also covers IHL values up to 15, padded frames and every unsupported-frame condition. A parity slip in the accumulators would give wrong sums on odd-length segments, and a pseudo-header wrongly added to ICMP would fail every ICMP frame. A wrong window end would add padding bytes to the sum. A missing short-frame test would report a sum instead of 0xFFFF. Random downstream backpressure and input gaps show a trailer byte that moves while stalled, or an enable value that is taken mid-frame instead of on the first byte.

// File: rtl/rxck_pkg.sv
package rxck_pkg;
    typedef enum logic [2:0] {ST_PASS, ST_TR0, ST_TR1, ST_TR2, ST_TR3} rx_st_e;

    localparam int unsigned SUM_W      = 32;
    localparam int unsigned L2_LEN     = 14;
    localparam int unsigned L3_END_MIN = 34;
    localparam int unsigned ADDR_BEG   = 26;
    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
    localparam logic [7:0]  PROTO_ICMP = 8'd1;
    localparam logic [7:0]  PROTO_TCP  = 8'd6;
    localparam logic [7:0]  PROTO_UDP  = 8'd17;

    function automatic logic [15:0] fold16(input logic [SUM_W-1:0] s);
        logic [16:0] t;
        t = {1'b0, s[15:0]} + {1'b0, s[31:16]};
        return t[15:0] + {15'd0, t[16]};
    endfunction
endpackage

// File: rtl/rxck_acc.sv
module rxck_acc #(
    parameter int unsigned SUM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add,
    input  logic             hi,
    input  logic [7:0]       byte_i,
    output logic [SUM_W-1:0] sum_o
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            sum_o <= '0;
        else if (add)
            sum_o <= sum_o + (hi ? SUM_W'({byte_i, 8'h00}) : SUM_W'(byte_i));
    end
endmodule

// File: rtl/rxck_hdr.sv
module rxck_hdr
    import rxck_pkg::*;
#(
    parameter int unsigned IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             fire,
    input  logic [7:0]       byte_i,
    output logic [IDX_W-1:0] idx,
    output logic [15:0]      etype,
    output logic [3:0]       ver,
    output logic [3:0]       ihl,
    output logic [15:0]      tot_len,
    output logic             frag,
    output logic [7:0]       proto,
    output logic             in_ip,
    output logic             in_l4,
    output logic             in_addr
);
    localparam int unsigned EW = ((IDX_W > 16) ? IDX_W : 16) + 1;
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic [EW-1:0] idx_x, hdr_end, pay_end;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx <= '0; etype <= '0; ver <= '0; ihl <= '0;
            tot_len <= '0; frag <= 1'b0; proto <= '0;
        end else if (fire) begin
            if (idx != IDX_MAX) idx <= idx + 1'b1;
            case (idx)
                IDX_W'(12): etype[15:8]   <= byte_i;
                IDX_W'(13): etype[7:0]    <= byte_i;
                IDX_W'(14): {ver, ihl}    <= byte_i;
                IDX_W'(16): tot_len[15:8] <= byte_i;
                IDX_W'(17): tot_len[7:0]  <= byte_i;
                IDX_W'(20): frag          <= byte_i[5] | (|byte_i[4:0]);
                IDX_W'(21): frag          <= frag | (|byte_i);
                IDX_W'(23): proto         <= byte_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        idx_x   = EW'(idx);
        hdr_end = EW'(L2_LEN) + EW'({ihl, 2'b00});
        pay_end = EW'(L2_LEN) + EW'(tot_len);
        in_ip   = (idx_x >= EW'(L2_LEN)) &&
                  ((idx_x < EW'(L3_END_MIN)) || (idx_x < hdr_end));
        in_l4   = (idx_x >= EW'(L3_END_MIN)) && (idx_x >= hdr_end) && (idx_x < pay_end);
        in_addr = (idx_x >= EW'(ADDR_BEG)) && (idx_x < EW'(L3_END_MIN));
    end
endmodule

// File: rtl/rx_csum_verify.sv
module rx_csum_verify
    import rxck_pkg::*;
#(
    parameter int unsigned IDX_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] chk_en,
    input  logic       s_valid,
    output logic       s_ready,
    input  logic [7:0] s_data,
    input  logic       s_last,
    output logic       m_valid,
    input  logic       m_ready,
    output logic [7:0] m_data,
    output logic       m_last
);
    localparam int unsigned EW    = ((IDX_W > 16) ? IDX_W : 16) + 1;
    localparam int unsigned N_ACC = 3;

    rx_st_e st_q, st_d;
    logic s_fire, clr;
    logic [3:0] cfg_q;

    logic [IDX_W-1:0] idx;
    logic [15:0] etype, tot_len;
    logic [3:0]  ver, ihl;
    logic        frag, in_ip, in_l4, in_addr;
    logic [7:0]  proto;
    logic [N_ACC-1:0] acc_add;
    logic [SUM_W-1:0] acc_sum [N_ACC];

    logic hdr_ok, l4_en;
    logic [15:0] ip_half, l4_half, l4_len;
    logic [SUM_W-1:0] l4_total;
    logic [31:0] trl;

    assign s_fire = s_valid && s_ready;
    assign clr    = (st_q == ST_TR3) && m_ready;

    rxck_hdr #(.IDX_W(IDX_W)) u_hdr (
        .clk(clk), .rst_n(rst_n), .clr(clr), .fire(s_fire), .byte_i(s_data),
        .idx(idx), .etype(etype), .ver(ver), .ihl(ihl), .tot_len(tot_len),
        .frag(frag), .proto(proto), .in_ip(in_ip), .in_l4(in_l4), .in_addr(in_addr)
    );

    assign acc_add = {in_addr, in_l4, in_ip} & {N_ACC{s_fire}};

    for (genvar g = 0; g < N_ACC; g++) begin : g_acc
        rxck_acc #(.SUM_W(SUM_W)) u_acc (
            .clk(clk), .rst_n(rst_n), .clr(clr), .add(acc_add[g]),
            .hi(~idx[0]), .byte_i(s_data), .sum_o(acc_sum[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (s_fire && (idx == '0))
            cfg_q <= chk_en;
    end

    // Trailer from the registered sums once the last byte has been taken.
    always_comb begin
        hdr_ok = (etype == ETYPE_IPV4) && (ver == 4'd4) && (ihl >= 4'd5) &&
                 (EW'(idx) >= EW'(L3_END_MIN)) &&
                 (EW'(idx) >= EW'(L2_LEN) + EW'(tot_len)) &&
                 (tot_len >= 16'({ihl, 2'b00}));
        unique case (proto)
            PROTO_TCP:  l4_en = cfg_q[1];
            PROTO_UDP:  l4_en = cfg_q[2];
            PROTO_ICMP: l4_en = cfg_q[3];
            default:    l4_en = 1'b0;
        endcase
        l4_len   = tot_len - 16'({ihl, 2'b00});
        l4_total = acc_sum[1];
        if (proto != PROTO_ICMP)
            l4_total = acc_sum[1] + acc_sum[2] + SUM_W'(proto) + SUM_W'(l4_len);
        ip_half = (hdr_ok && cfg_q[0]) ? ~fold16(acc_sum[0]) : 16'hFFFF;
        l4_half = (hdr_ok && !frag && l4_en) ? ~fold16(l4_total) : 16'hFFFF;
        trl     = {ip_half, l4_half};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_PASS;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_PASS: if (s_fire && s_last) st_d = ST_TR0;
            ST_TR0:  if (m_ready) st_d = ST_TR1;
            ST_TR1:  if (m_ready) st_d = ST_TR2;
            ST_TR2:  if (m_ready) st_d = ST_TR3;
            ST_TR3:  if (m_ready) st_d = ST_PASS;
            default: st_d = ST_PASS;
        endcase
    end

    always_comb begin
        s_ready = 1'b0;
        m_valid = 1'b1;
        m_last  = 1'b0;
        m_data  = trl[31:24];
        unique case (st_q)
            ST_PASS: begin
                s_ready = m_ready;
                m_valid = s_valid;
                m_data  = s_data;
            end
            ST_TR0: m_data = trl[31:24];
            ST_TR1: m_data = trl[23:16];
            ST_TR2: m_data = trl[15:8];
            ST_TR3: begin
                m_data = trl[7:0];
                m_last = 1'b1;
            end
            default: m_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/rx_csum_verify_chk.sv
module rx_csum_verify_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       s_valid,
    input logic       s_ready,
    input logic [7:0] s_data,
    input logic       s_last,
    input logic       m_valid,
    input logic       m_ready,
    input logic [7:0] m_data,
    input logic       m_last
);
    logic       in_tr;
    logic [1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_tr <= 1'b0;
            cnt   <= '0;
        end else if (m_valid && m_ready && m_last) begin
            in_tr <= 1'b0;
            cnt   <= '0;
        end else if (s_valid && s_ready && s_last) begin
            in_tr <= 1'b1;
            cnt   <= '0;
        end else if (in_tr && m_valid && m_ready) begin
            cnt <= cnt + 2'd1;
        end
    end

    p_trail_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_tr |-> (m_valid && !s_ready));

    p_last_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_last) |-> (in_tr && cnt == 2'd3));

    p_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_tr |-> ((s_ready == m_ready) && (m_valid == s_valid) && !m_last));

    p_pass_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_tr && s_valid) |-> (m_data == s_data));

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_tr && !m_ready) |=> ($stable(m_data) && $stable(m_last) && m_valid));
endmodule

bind rx_csum_verify rx_csum_verify_chk u_chk (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_last(m_last)
);

// File: tb/sim_rx_csum_verify.sv
module sim_rx_csum_verify;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] chk_en;
    logic       s_valid, s_ready, s_last, m_valid, m_ready, m_last;
    logic [7:0] s_data, m_data;

    always #10 clk = ~clk;

    rx_csum_verify u0 (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0] fr [0:255];
    int fr_len;

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        wait (cycles >= 190000);
        errors++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [15:0] fold(input logic [31:0] s);
        logic [16:0] t;
        t = {1'b0, s[15:0]} + {1'b0, s[31:16]};
        return t[15:0] + {15'd0, t[16]};
    endfunction

    function automatic logic [31:0] bsum(input int a, input int b);
        logic [31:0] s = 0;
        for (int k = a; k < b; k++)
            s += (((k - a) % 2) == 0) ? {16'd0, fr[k], 8'h00} : {24'd0, fr[k]};
        return s;
    endfunction

    // Expected trailer from the requirements (R4..R10).
    function automatic logic [31:0] ref_trl(input logic [3:0] en);
        int ihl4, tl;
        logic ok, fragm, l4en;
        logic [7:0] pr;
        logic [31:0] s;
        logic [15:0] iph = 16'hFFFF, l4h = 16'hFFFF;
        ok = fr_len >= 34;
        if (ok) begin
            ihl4 = int'(fr[14][3:0]) * 4;
            tl   = int'({fr[16], fr[17]});
            ok = ({fr[12], fr[13]} == 16'h0800) && (fr[14][7:4] == 4'd4) &&
                 (ihl4 >= 20) && (tl >= ihl4) && (fr_len >= 14 + tl);
        end
        if (ok) begin
            if (en[0]) iph = ~fold(bsum(14, 14 + ihl4));
            pr    = fr[23];
            fragm = fr[20][5] || (fr[20][4:0] != 0) || (fr[21] != 0);
            l4en  = (pr == 6 && en[1]) || (pr == 17 && en[2]) || (pr == 1 && en[3]);
            if (!fragm && l4en) begin
                s = bsum(14 + ihl4, 14 + tl);
                if (pr != 1) s += bsum(26, 34) + 32'(pr) + 32'(tl - ihl4);
                l4h = ~fold(s);
            end
        end
        return {iph, l4h};
    endfunction

    task automatic build(input logic [15:0] et, input logic [7:0] pr, input int ihl,
                         input int seglen, input int pad, input int tl_extra,
                         input logic [7:0] flg);
        int ihl4 = ihl * 4;
        int tl = ihl4 + seglen + tl_extra;
        int l4s = 14 + ihl4;
        int off = (pr == 6) ? 16 : (pr == 17) ? 6 : 2;
        logic [31:0] s;
        logic [15:0] ck;
        for (int k = 0; k < 12; k++) fr[k] = 8'(k * 7 + 3);
        fr[12] = et[15:8]; fr[13] = et[7:0];
        fr[14] = {4'h4, 4'(ihl)}; fr[15] = 8'h00;
        fr[16] = 8'(tl >> 8); fr[17] = 8'(tl);
        fr[18] = 8'h12; fr[19] = 8'h34; fr[20] = flg; fr[21] = 8'h00;
        fr[22] = 8'd64; fr[23] = pr; fr[24] = 8'h00; fr[25] = 8'h00;
        fr[26] = 8'd10; fr[27] = 8'd1; fr[28] = 8'd2; fr[29] = 8'(seglen);
        fr[30] = 8'd192; fr[31] = 8'd168; fr[32] = 8'd7; fr[33] = 8'(ihl * 3 + 9);
        for (int k = 34; k < l4s; k++) fr[k] = 8'(k + 1);
        for (int k = 0; k < seglen; k++) fr[l4s + k] = 8'(k * 13 + 5 + seglen);
        if (seglen >= off + 2) begin
            fr[l4s + off] = 8'h00; fr[l4s + off + 1] = 8'h00;
            s = bsum(l4s, l4s + seglen);
            if (pr != 1) s += bsum(26, 34) + 32'(pr) + 32'(seglen);
            ck = ~fold(s);
            fr[l4s + off] = ck[15:8]; fr[l4s + off + 1] = ck[7:0];
        end
        ck = ~fold(bsum(14, l4s));
        fr[24] = ck[15:8]; fr[25] = ck[7:0];
        for (int k = 0; k < pad; k++) fr[l4s + seglen + k] = 8'hA5;
        fr_len = l4s + seglen + pad;
    endtask

    task automatic fix_ip();
        logic [15:0] ck;
        fr[24] = 8'h00; fr[25] = 8'h00;
        ck = ~fold(bsum(14, 14 + int'(fr[14][3:0]) * 4));
        fr[24] = ck[15:8]; fr[25] = ck[7:0];
    endtask

    task automatic send(input logic [3:0] en, input logic mid, input string tag);
        logic [31:0] exp_t = ref_trl(en);
        logic [31:0] got_t = 0;
        logic [7:0] eb;
        int src = 0, oi = 0, nb = 0, bad_k = -1, last_k = -1, n = 0;
        logic [7:0] bad_g = 0, bad_e = 0;
        logic done = 0;
        while (!done) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            s_valid = (src < fr_len) && (lfsr[2:0] != 3'd0);
            s_data  = (src < fr_len) ? fr[src] : 8'h00;
            s_last  = (src == fr_len - 1);
            m_ready = (lfsr[5:4] != 2'd0);
            chk_en  = (mid && src > 0) ? ~en : en;
            #5;
            if (s_valid && s_ready) src++;
            if (m_valid && m_ready) begin
                if (oi < fr_len) begin
                    eb = fr[oi];
                    if (m_data !== eb && bad_k < 0) begin
                        bad_k = oi; bad_g = m_data; bad_e = eb;
                    end
                    if (m_data !== eb) nb++;
                end else begin
                    got_t = {got_t[23:0], m_data};
                end
                if (m_last) begin
                    last_k = oi;
                    done = 1;
                end
                oi++;
            end
            n++;
            if (n > 5000) begin
                errors++;
                $display("FAIL watchdog %s R1: frame stuck, actual %0d bytes out expected %0d",
                         tag, oi, fr_len + 4);
                return;
            end
        end
        // R1 R12: frame bytes unchanged under gaps and backpressure
        checks++;
        if (nb != 0) begin
            errors++;
            $display("FAIL %s R1 R12: byte %0d actual %02h expected %02h", tag, bad_k, bad_g, bad_e);
        end
        // R3 and the per-case requirement: trailer value and order
        checks++;
        if (got_t !== exp_t) begin
            errors++;
            $display("FAIL %s R3: trailer actual %08h expected %08h", tag, got_t, exp_t);
        end
        // R2: last only on fourth trailer byte
        checks++;
        if (last_k != fr_len + 3) begin
            errors++;
            $display("FAIL %s R2: last at byte %0d expected %0d", tag, last_k, fr_len + 3);
        end
    endtask

    initial begin
        logic [7:0] pr;
        int base;
        rst_n = 0; s_valid = 0; s_data = 0; s_last = 0; m_ready = 1; chk_en = 4'hF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #5;
        // R13: reset state
        checks++;
        if (m_valid !== 1'b0 || m_last !== 1'b0 || s_ready !== 1'b1) begin
            errors++;
            $display("FAIL R13 reset: actual v=%b l=%b r=%b expected 0 0 1", m_valid, m_last, s_ready);
        end

        for (int p = 0; p < 3; p++) begin
            pr   = (p == 0) ? 8'd6 : (p == 1) ? 8'd17 : 8'd1;
            base = (p == 0) ? 20 : 8;
            for (int sl = base; sl < base + 10; sl++) begin
                build(16'h0800, pr, 5, sl, 0, 0, 8'h40);
                send(4'hF, 0, "R4 R5 good");
                build(16'h0800, pr, 5, sl, 0, 0, 8'h40);
                fr[14 + 20 + sl - 1] ^= 8'h01;
                send(4'hF, 0, "R5 bad segment");
            end
            build(16'h0800, pr, 5, base + 3, 0, 0, 8'h40);
            fr[22] = 8'd63;
            send(4'hF, 0, "R4 bad header");
            for (int e = 0; e < 16; e++) begin
                build(16'h0800, pr, 5, base + 5, 0, 0, 8'h40);
                send(4'(e), 0, "R6 enable sweep");
            end
        end

        for (int ih = 6; ih <= 15; ih += 3) begin
            build(16'h0800, 8'd6, ih, 23, 0, 0, 8'h40);
            send(4'hF, 0, "R4 options");
        end
        build(16'h0800, 8'd17, 15, 9, 0, 0, 8'h40);
        send(4'hF, 0, "R4 ihl 15");

        build(16'h86DD, 8'd6, 5, 24, 0, 0, 8'h40);
        send(4'hF, 0, "R7 ipv6 type");
        build(16'h0806, 8'd6, 5, 24, 0, 0, 8'h40);
        send(4'hF, 0, "R7 arp type");

        build(16'h0800, 8'd6, 5, 24, 0, 0, 8'h40);
        fr[14] = 8'h44; fix_ip();
        send(4'hF, 0, "R8 ihl 4");
        build(16'h0800, 8'd6, 5, 24, 0, 0, 8'h40);
        fr[14] = 8'h65; fix_ip();
        send(4'hF, 0, "R8 version 6");
        build(16'h0800, 8'd6, 5, 24, 0, 5, 8'h40);
        send(4'hF, 0, "R8 short frame");
        build(16'h0800, 8'd6, 5, 24, 0, 0, 8'h40);
        fr[16] = 8'h00; fr[17] = 8'd16; fix_ip();
        send(4'hF, 0, "R8 total below ihl");
        build(16'h0800, 8'd6, 5, 24, 0, 0, 8'h40);
        fr_len = 20;
        send(4'hF, 0, "R8 tiny frame");

        build(16'h0800, 8'd6, 5, 24, 0, 0, 8'h20);
        send(4'hF, 0, "R9 more fragments");
        build(16'h0800, 8'd17, 5, 12, 0, 0, 8'h00);
        fr[21] = 8'h08; fix_ip();
        send(4'hF, 0, "R9 frag offset");
        build(16'h0800, 8'd2, 5, 12, 0, 0, 8'h40);
        send(4'hF, 0, "R9 other protocol");

        for (int pd = 1; pd <= 6; pd++) begin
            build(16'h0800, (pd % 2) ? 8'd17 : 8'd6, 5, 21 + pd, pd, 0, 8'h40);
            send(4'hF, 0, "R10 padding");
        end

        build(16'h0800, 8'd6, 5, 30, 0, 0, 8'h40);
        send(4'hF, 1, "R11 enables dropped mid frame");
        build(16'h0800, 8'd6, 5, 30, 0, 0, 8'h40);
        send(4'h0, 1, "R11 enables raised mid frame");
        build(16'h0800, 8'd1, 5, 31, 0, 0, 8'h40);
        send(4'h9, 1, "R11 partial mid frame");

        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule